// File: doc/BRIEF.md
# I/O-Byte Port and Low-Memory Bank Bridge

This block sits between an 8-bit CPU core that has split data-in and data-out buses and two kinds of storage: a 512 KB byte-wide SRAM with a shared bidirectional data bus, and an external system bus. It produces the SRAM address, the chip and strobe controls, and the drive enable for the SRAM data pins. It also decides which source feeds the CPU data-in bus on every read cycle.

One I/O port serves two purposes. A read of that port returns eight configuration switches. A write to it loads a bank register that picks which 32 KB SRAM page appears in the CPU's lower half (0000h–7FFFh). The upper half always maps to a fixed page that no bank value can reach. A lamp output shows when an alternate low page is in use. Any read that no on-board source claims goes to the external bus. Those sources are the SRAM, the switch port and a serial peripheral, and when one of them claims a read, the external-bus input buffers are disabled.

Top module: `iob_bank_bridge`

## Requirements
- R1: After reset the bank register is 0, bank_led is low, sram_oe_n is high and sram_dq_oe is low.
- R2: An I/O read whose low address byte is 36h drives cpu_din with sw_in and holds bus_buf_en low. The high address byte is not decoded.
- R3: An I/O write to port 36h loads the bank register from cpu_dout on the clock edge where io_wr is high. With bank value 1, CPU addresses 0000h–7FFFh drive sram_addr[18:15]=1 and bank_led is high. Writing 00h restores page 0 and drives bank_led low.
- R4: CPU addresses 8000h–FFFFh always drive sram_addr[18:15]=HIGH_PAGE (default 0Fh), and sram_addr[14:0]=cpu_addr[14:0], whatever the bank value.
- R5: An I/O read that neither the switch port nor the serial port claims drives cpu_din with bus_din and bus_buf_en high.
- R6: An I/O read with ser_claim high, to any port other than 36h, drives cpu_din with ser_rdata and holds bus_buf_en low.
- R7: When more than one on-board source claims a read, the priority is SRAM (any memory read), then the switch port, then the serial port.
- R8: sram_we_n is low and sram_dq_oe is high only while mem_wr is high. sram_dq_out equals cpu_dout.
- R9: sram_oe_n goes low only from the second clock of a memory read. It is never low in a cycle that follows a cycle in which sram_dq_oe was high.
- R10: Only bank register bits [BANK_W-1:0] (default 1 bit) are loaded. With the default, a write of 02h selects page 0 and a write of 03h selects page 1. I/O writes to other ports, and memory writes to address 0036h, leave the bank unchanged.
- R11: sram_ce_n is low during a memory read or write and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_dout | input | 8 | CPU write data |
| mem_rd | input | 1 | Memory read strobe, active high |
| mem_wr | input | 1 | Memory write strobe, active high |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| sw_in | input | 8 | Configuration switches |
| bus_din | input | 8 | External bus read data |
| ser_rdata | input | 8 | Serial peripheral read data |
| ser_claim | input | 1 | Serial peripheral claims the current I/O read |
| sram_dq_in | input | 8 | Data sampled from SRAM pins |
| sram_addr | output | 19 | SRAM address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_dq_out | output | 8 | Data to drive on SRAM pins |
| sram_dq_oe | output | 1 | Pin drive enable for SRAM data |
| bus_buf_en | output | 1 | External bus input buffer enable |
| cpu_din | output | 8 | CPU read data |
| bank_led | output | 1 | High while a non-zero low page is selected |

## Verification
Source selection, SRAM address mapping, chip enable and write enable are combinational, so those results are due in the same cycle as the stimulus. The bench applies inputs after a falling edge and samples before the next rising edge. A bank write takes effect after the one rising edge that samples io_wr, so the bench checks the mapping and the lamp after that edge. The output enable is due one rising edge after a memory read begins. The bench checks that it is still high in the first cycle and low in the second.

// File: rtl/iob_pkg.sv
package iob_pkg;
  localparam int PAGE_W = 4;

  typedef enum logic [1:0] {SRC_BUS, SRC_SRAM, SRC_IOB, SRC_SER} src_t;

  // Fixed-priority source choice for a CPU read cycle.
  function automatic src_t pick_src(input logic mem_rd, input logic io_rd,
                                    input logic iob_hit, input logic ser_claim);
    if (mem_rd)                  return SRC_SRAM;
    else if (io_rd && iob_hit)   return SRC_IOB;
    else if (io_rd && ser_claim) return SRC_SER;
    else                         return SRC_BUS;
  endfunction

  // SRAM page for a CPU address: bank page below 8000h, fixed page above.
  function automatic logic [PAGE_W-1:0] page_of(input logic a15,
                                                input logic [PAGE_W-1:0] bank,
                                                input logic [PAGE_W-1:0] high_pg);
    return a15 ? high_pg : bank;
  endfunction
endpackage

// File: rtl/iob_bank_reg.sv
module iob_bank_reg #(
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              port_hit,
  input  logic [7:0]        wdata,
  output logic [BANK_W-1:0] bank
);
  logic load;
  assign load = io_wr && port_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)    bank <= '0;
    else if (load) bank <= wdata[BANK_W-1:0];
  end

  assert_bank_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> bank == '0);

  assert_bank_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) && $past(rst_n) |-> bank == $past(wdata[BANK_W-1:0]));

  assert_bank_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!load) && $past(rst_n) |-> $stable(bank));
endmodule

// File: rtl/iob_sram_ctl.sv
module iob_sram_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_rd,
  input  logic       mem_wr,
  input  logic [7:0] cpu_dout,
  output logic       sram_ce_n,
  output logic       sram_oe_n,
  output logic       sram_we_n,
  output logic [7:0] sram_dq_out,
  output logic       sram_dq_oe
);
  logic rd_seen;
  logic rd_live;

  assign rd_live = mem_rd && !mem_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_seen <= 1'b0;
    else        rd_seen <= rd_live;
  end

  assign sram_we_n   = !mem_wr;
  assign sram_dq_oe  = mem_wr;
  assign sram_dq_out = cpu_dout;
  assign sram_oe_n   = !(rd_seen && rd_live);
  assign sram_ce_n   = !(mem_rd || mem_wr);

  assert_oe_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> $past(!sram_dq_oe));

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  assert_oe_needs_chip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_ce_n);
endmodule

// File: rtl/iob_din_mux.sv
module iob_din_mux
  import iob_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_rd,
  input  logic       io_rd,
  input  logic       iob_hit,
  input  logic       ser_claim,
  input  logic [7:0] sram_dq_in,
  input  logic [7:0] sw_in,
  input  logic [7:0] ser_rdata,
  input  logic [7:0] bus_din,
  output logic [7:0] cpu_din,
  output logic       bus_buf_en
);
  src_t src;
  logic onboard;

  assign src     = pick_src(mem_rd, io_rd, iob_hit, ser_claim);
  assign onboard = (src != SRC_BUS);

  always_comb begin
    unique case (src)
      SRC_SRAM: cpu_din = sram_dq_in;
      SRC_IOB:  cpu_din = sw_in;
      SRC_SER:  cpu_din = ser_rdata;
      default:  cpu_din = bus_din;
    endcase
  end

  assign bus_buf_en = (mem_rd || io_rd) && !onboard;

  assert_claim_blocks_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && ser_claim) |-> !bus_buf_en);

  assert_switch_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !mem_rd && iob_hit) |-> (cpu_din == sw_in && !bus_buf_en));
endmodule

// File: rtl/iob_bank_bridge.sv
module iob_bank_bridge
  import iob_pkg::*;
#(
  parameter int          BANK_W    = 1,      // 1..3
  parameter logic [7:0]  IOB_PORT  = 8'h36,
  parameter logic [3:0]  HIGH_PAGE = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_dout,
  input  logic        mem_rd,
  input  logic        mem_wr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [7:0]  sw_in,
  input  logic [7:0]  bus_din,
  input  logic [7:0]  ser_rdata,
  input  logic        ser_claim,
  input  logic [7:0]  sram_dq_in,
  output logic [18:0] sram_addr,
  output logic        sram_ce_n,
  output logic        sram_oe_n,
  output logic        sram_we_n,
  output logic [7:0]  sram_dq_out,
  output logic        sram_dq_oe,
  output logic        bus_buf_en,
  output logic [7:0]  cpu_din,
  output logic        bank_led
);
  localparam int PAD_W = PAGE_W - BANK_W;

  logic              iob_hit;
  logic [BANK_W-1:0] bank;
  logic [PAGE_W-1:0] bank_pg;
  logic [PAGE_W-1:0] page;

  assign iob_hit = (cpu_addr[7:0] == IOB_PORT);

  iob_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .port_hit(iob_hit),
    .wdata(cpu_dout), .bank(bank)
  );

  assign bank_pg   = {{PAD_W{1'b0}}, bank};
  assign page      = page_of(cpu_addr[15], bank_pg, HIGH_PAGE);
  assign sram_addr = {page, cpu_addr[14:0]};
  assign bank_led  = (bank != '0);

  iob_sram_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .cpu_dout(cpu_dout), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe)
  );

  iob_din_mux u_mux (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .io_rd(io_rd),
    .iob_hit(iob_hit), .ser_claim(ser_claim), .sram_dq_in(sram_dq_in),
    .sw_in(sw_in), .ser_rdata(ser_rdata), .bus_din(bus_din),
    .cpu_din(cpu_din), .bus_buf_en(bus_buf_en)
  );

  assert_high_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15] |-> sram_addr[18:15] == HIGH_PAGE);

  assert_low_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[15] |-> (sram_addr[18:15] != HIGH_PAGE && bank_led == (sram_addr[18:15] != 4'd0)));
endmodule

// File: tb/sim_iob_bank_bridge.sv
module sim_iob_bank_bridge;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_dout, sw_in, bus_din, ser_rdata, sram_dq_in;
  logic        mem_rd, mem_wr, io_rd, io_wr, ser_claim;
  logic [18:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, bus_buf_en, bank_led;
  logic [7:0]  sram_dq_out, cpu_din;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  iob_bank_bridge u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_dout(cpu_dout),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .sw_in(sw_in), .bus_din(bus_din), .ser_rdata(ser_rdata), .ser_claim(ser_claim),
    .sram_dq_in(sram_dq_in), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .bus_buf_en(bus_buf_en), .cpu_din(cpu_din),
    .bank_led(bank_led)
  );

  // {is_io, addr, ser_claim, expected cpu_din, expected bus_buf_en}
  localparam int NV = 8;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 16'h1234, 1'b0, 8'h5A, 1'b0},  // R7 memory read -> SRAM
    {1'b1, 16'h0036, 1'b0, 8'hA5, 1'b0},  // R2 switch port
    {1'b1, 16'h0010, 1'b0, 8'h3C, 1'b1},  // R5 unclaimed -> bus
    {1'b1, 16'h0020, 1'b1, 8'h96, 1'b0},  // R6 serial claim
    {1'b0, 16'h8000, 1'b1, 8'h5A, 1'b0},  // R7 SRAM beats serial
    {1'b1, 16'h0036, 1'b1, 8'hA5, 1'b0},  // R7 switch port beats serial
    {1'b1, 16'h1236, 1'b0, 8'hA5, 1'b0},  // R2 high byte not decoded
    {1'b1, 16'h0037, 1'b0, 8'h3C, 1'b1}   // R5 neighbour port -> bus
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    mem_rd = 0; mem_wr = 0; io_rd = 0; io_wr = 0; ser_claim = 0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); idle(); cpu_addr = a; cpu_dout = d; io_wr = 1;
    @(negedge clk); idle();
  endtask

  task automatic mem_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); idle(); cpu_addr = a; cpu_dout = d; mem_wr = 1;
    @(negedge clk); idle();
  endtask

  task automatic page_at(input string tag, input logic [15:0] a, input logic [18:0] exp);
    @(negedge clk); idle(); cpu_addr = a; mem_rd = 1;
    #1 chk(tag, sram_addr, exp);
  endtask

  initial begin
    #(200000 * CLK_P);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    idle(); rst_n = 0; cpu_addr = 0; cpu_dout = 0;
    sw_in = 8'hA5; bus_din = 8'h3C; ser_rdata = 8'h96; sram_dq_in = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bank_led", bank_led, 0);
    chk("R1 oe_n", sram_oe_n, 1);
    chk("R1 dq_oe", sram_dq_oe, 0);
    chk("R11 ce_n idle", sram_ce_n, 1);
    page_at("R1 page0 after reset", 16'h0100, 19'h00100);

    // Table of read-source vectors
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); idle();
      cpu_addr  = VEC[i][25:10];
      ser_claim = VEC[i][9];
      if (VEC[i][26]) io_rd = 1; else mem_rd = 1;
      #1;
      chk($sformatf("R2/R5/R6/R7 vec%0d din", i), cpu_din, VEC[i][8:1]);
      chk($sformatf("R2/R5/R6/R7 vec%0d buf", i), bus_buf_en, VEC[i][0]);
    end

    // R3 bank switching
    io_write(16'h0036, 8'h01);
    chk("R3 led on", bank_led, 1);
    page_at("R3 page1 low", 16'h1234, 19'h09234);
    page_at("R4 high with bank1", 16'h9234, 19'h79234);
    io_write(16'h0036, 8'h00);
    chk("R3 led off", bank_led, 0);
    page_at("R3 page0 restored", 16'h1234, 19'h01234);
    page_at("R4 high with bank0", 16'hFFFF, 19'h7FFFF);

    // R10 width and ignored writes
    io_write(16'h0036, 8'h02);
    page_at("R10 upper bits dropped", 16'h0000, 19'h00000);
    io_write(16'h0036, 8'h03);
    page_at("R10 low bit kept", 16'h0000, 19'h08000);
    io_write(16'h0037, 8'h00);
    page_at("R10 other port ignored", 16'h0000, 19'h08000);
    mem_write(16'h0036, 8'h00);
    chk("R10 mem write ignored led", bank_led, 1);
    io_write(16'h0036, 8'h00);

    // R8 / R11 write cycle
    @(negedge clk); idle(); cpu_addr = 16'h4000; cpu_dout = 8'hC3; mem_wr = 1;
    #1;
    chk("R8 we_n", sram_we_n, 0);
    chk("R8 dq_oe", sram_dq_oe, 1);
    chk("R8 dq_out", sram_dq_out, 8'hC3);
    chk("R11 ce_n write", sram_ce_n, 0);
    chk("R9 oe_n during write", sram_oe_n, 1);

    // R9 read directly after write: oe waits one clock
    @(negedge clk); idle(); mem_rd = 1;
    #1;
    chk("R8 dq released", sram_dq_oe, 0);
    chk("R9 oe_n first read cycle", sram_oe_n, 1);
    chk("R11 ce_n read", sram_ce_n, 0);
    @(negedge clk); #1;
    chk("R9 oe_n second read cycle", sram_oe_n, 0);
    @(negedge clk); idle(); #1;
    chk("R9 oe_n after read", sram_oe_n, 1);
    chk("R8 we_n idle", sram_we_n, 1);

    // R1 reset clears a selected bank
    io_write(16'h0036, 8'h01);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 bank cleared by reset", bank_led, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule